// File: doc/BRIEF.md
# Timestamp-Based Scanline Estimator

This block works out which display line the raster is currently on, for cases where a direct line counter cannot be trusted. A free-running timestamp counter advances on a tick input, and each start-of-vertical-blank strobe copies the counter's value into a frame-time register. On request, the block converts the time elapsed since that copy into a whole number of lines. It does this by scaling the elapsed time by the pixel clock in kHz and dividing by one thousand times the line length. It then clamps the line count to one below the frame height and rebases it to the vertical-blank start line, wrapping modulo the frame height.

The frame-time register is read once before and once after the current time is sampled. If a vertical-blank strobe lands between these two reads, the pair is discarded and the sampling starts again, so both values always come from the same frame. The division runs on an iterative restoring divider that produces one quotient bit per clock. The result appears with a single-cycle valid pulse. Requests that arrive while a computation is in flight are dropped.

Top module: `scanline_estimator`

## Requirements
- R1: After synchronous reset, `scanline` is 0 and `valid` is 0.
- R2: The timestamp counter increments by one on each clock edge where `ts_tick` is 1. A clock edge with `vblank_stb` at 1 copies the counter's value from before that edge's increment into the frame-time register.
- R3: The elapsed line count is floor(((now - frame_time) mod 2^TS_W) * `pclk_khz` / (1000 * `htotal`)). The product is formed at full TS_W+CLK_W width, so products above 2^32 keep all their bits.
- R4: An elapsed line count greater than `vtotal`-1 is replaced by `vtotal`-1.
- R5: The reported `scanline` is (clamped line count + `vblank_line`) mod `vtotal`, with `vblank_line` < `vtotal`.
- R6: If the frame-time register changes between the sample taken before reading the current time and the sample taken after it, the block resamples. The result then reflects the new frame time.
- R7: `valid` is a single-cycle pulse. `scanline` changes only in a cycle where `valid` is 1 and holds its value otherwise.
- R8: A `req` raised while a computation is in progress is ignored: it produces no extra `valid` pulse and no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_stb | input | 1 | Start-of-vertical-blank strobe; captures the timestamp |
| ts_tick | input | 1 | Advances the free-running timestamp counter |
| htotal | input | LINE_W | Line length in pixels |
| vtotal | input | LINE_W | Frame height in lines |
| vblank_line | input | LINE_W | Line number at which vertical blank starts |
| pclk_khz | input | CLK_W | Pixel clock in kHz |
| req | input | 1 | Start an estimate (accepted when idle) |
| scanline | output | LINE_W | Estimated current line, registered |
| valid | output | 1 | One-cycle pulse when `scanline` is updated |

## Verification
The main function is tried against several elapsed-time patterns. Small counts whose rebased sum stays below the frame height check the plain scaling and truncation. Counts whose sum crosses the frame height show the modulo wrap. Counts far past the frame height and one landing exactly on `vtotal`-1 separate the clamp from the wrap. A zero elapsed time returns the vblank line itself. A product above 2^32 shows whether the full-width multiply is kept. Directed cases inject a vblank strobe between the two frame-time reads, which tells a retried result from a stale one. They also fire requests into a busy computation and count the valid pulses.

// File: rtl/scanline_est_pkg.sv
package scanline_est_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_CUR,
    ST_POST,
    ST_MUL,
    ST_DIV,
    ST_FIN
  } est_state_t;

  localparam int unsigned MS_PER_S_DIV = 1000;

endpackage

// File: rtl/sle_timebase.sv
module sle_timebase #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            capture,
  output logic [TS_W-1:0] ts_cnt,
  output logic [TS_W-1:0] frame_ts
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_cnt   <= '0;
      frame_ts <= '0;
    end else begin
      if (tick)    ts_cnt   <= ts_cnt + TS_W'(1);
      if (capture) frame_ts <= ts_cnt;
    end
  end

endmodule

// File: rtl/sle_divider.sv
module sle_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic [NUM_W-1:0] quot,
  output logic             done
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] left_q;
  logic             run_q;

  logic [DEN_W:0]   trial;
  logic             fits;

  always_comb begin
    trial = {rem_q, num_q[NUM_W-1]};
    fits  = (trial >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      quot   <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q  <= '0;
        num_q  <= numer;
        den_q  <= denom;
        quot   <= '0;
        left_q <= CNT_W'(NUM_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        num_q  <= {num_q[NUM_W-2:0], 1'b0};
        quot   <= {quot[NUM_W-2:0], fits};
        left_q <= left_q - CNT_W'(1);
        if (left_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/scanline_estimator.sv
module scanline_estimator
  import scanline_est_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int CLK_W  = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vblank_stb,
  input  logic              ts_tick,
  input  logic [LINE_W-1:0] htotal,
  input  logic [LINE_W-1:0] vtotal,
  input  logic [LINE_W-1:0] vblank_line,
  input  logic [CLK_W-1:0]  pclk_khz,
  input  logic              req,
  output logic [LINE_W-1:0] scanline,
  output logic              valid
);

  localparam int PROD_W = TS_W + CLK_W;
  localparam int DEN_W  = LINE_W + $clog2(MS_PER_S_DIV);

  est_state_t        state;
  logic [TS_W-1:0]   ts_cnt, frame_ts;
  logic [TS_W-1:0]   prev_q, cur_q;
  logic [TS_W-1:0]   elapsed_ts;
  logic [PROD_W-1:0] prod_q;
  logic [DEN_W-1:0]  den_q;
  logic              div_start;
  logic [PROD_W-1:0] quot;
  logic              div_done;
  logic [LINE_W-1:0] lines_c;
  logic [LINE_W:0]   sum_c;
  logic [LINE_W-1:0] rebased_c;

  sle_timebase #(.TS_W(TS_W)) u_timebase (
    .clk      (clk),
    .rst      (rst),
    .tick     (ts_tick),
    .capture  (vblank_stb),
    .ts_cnt   (ts_cnt),
    .frame_ts (frame_ts)
  );

  sle_divider #(.NUM_W(PROD_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .numer (prod_q),
    .denom (den_q),
    .quot  (quot),
    .done  (div_done)
  );

  always_comb begin
    elapsed_ts = cur_q - prev_q;
    if (quot >= PROD_W'(vtotal)) lines_c = vtotal - LINE_W'(1);
    else                         lines_c = quot[LINE_W-1:0];
    sum_c = {1'b0, lines_c} + {1'b0, vblank_line};
    if (sum_c >= {1'b0, vtotal}) sum_c = sum_c - {1'b0, vtotal};
    rebased_c = sum_c[LINE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      prev_q    <= '0;
      cur_q     <= '0;
      prod_q    <= '0;
      den_q     <= '0;
      div_start <= 1'b0;
      scanline  <= '0;
      valid     <= 1'b0;
    end else begin
      valid     <= 1'b0;
      div_start <= 1'b0;
      case (state)
        ST_IDLE: if (req) state <= ST_PRE;
        ST_PRE: begin
          prev_q <= frame_ts;
          state  <= ST_CUR;
        end
        ST_CUR: begin
          cur_q <= ts_cnt;
          state <= ST_POST;
        end
        ST_POST: state <= (frame_ts != prev_q) ? ST_PRE : ST_MUL;
        ST_MUL: begin
          prod_q    <= PROD_W'(elapsed_ts) * PROD_W'(pclk_khz);
          den_q     <= DEN_W'(htotal) * DEN_W'(MS_PER_S_DIV);
          div_start <= 1'b1;
          state     <= ST_DIV;
        end
        ST_DIV: if (div_done) state <= ST_FIN;
        ST_FIN: begin
          scanline <= rebased_c;
          valid    <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scanline_estimator_chk.sv
module scanline_estimator_chk #(
  parameter int TS_W   = 32,
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              vblank_stb,
  input logic              ts_tick,
  input logic [LINE_W-1:0] vtotal,
  input logic [LINE_W-1:0] scanline,
  input logic              valid,
  input logic [TS_W-1:0]   ts_cnt,
  input logic [TS_W-1:0]   frame_ts
);

  // R2
  ts_step_chk: assert property (@(posedge clk) disable iff (rst)
    ts_tick |=> ts_cnt == $past(ts_cnt) + TS_W'(1));

  // R2
  frame_cap_chk: assert property (@(posedge clk) disable iff (rst)
    vblank_stb |=> frame_ts == $past(ts_cnt));

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7
  scanline_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(scanline) |-> valid);

  // R5
  scanline_range_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> scanline < vtotal);

endmodule

bind scanline_estimator scanline_estimator_chk #(.TS_W(TS_W), .LINE_W(LINE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .vblank_stb (vblank_stb),
  .ts_tick    (ts_tick),
  .vtotal     (vtotal),
  .scanline   (scanline),
  .valid      (valid),
  .ts_cnt     (ts_cnt),
  .frame_ts   (frame_ts)
);

// File: tb/scanline_estimator_tb.sv
module scanline_estimator_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vblank_stb = 1'b0;
  logic        ts_tick = 1'b0;
  logic [15:0] htotal = 16'd100;
  logic [15:0] vtotal = 16'd50;
  logic [15:0] vblank_line = 16'd0;
  logic [31:0] pclk_khz = 32'd10000;
  logic        req = 1'b0;
  logic [15:0] scanline;
  logic        valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  scanline_estimator dut_i (
    .clk(clk), .rst(rst), .vblank_stb(vblank_stb), .ts_tick(ts_tick),
    .htotal(htotal), .vtotal(vtotal), .vblank_line(vblank_line),
    .pclk_khz(pclk_khz), .req(req), .scanline(scanline), .valid(valid)
  );

  // columns: elapsed ticks, pclk kHz, htotal, vtotal, vblank line, expected
  localparam int unsigned NV = 7;
  localparam int unsigned VEC [NV][6] = '{
    '{100,   20000,  100,  50,  40,   10},  // R5 wrap past vtotal
    '{30,    10000,  100,  50,  20,   23},  // R3 plain scaling
    '{500,   20000,  100,  50,  40,   39},  // R4 clamp then wrap
    '{0,     20000,  100,  50,  45,   45},  // R5 zero elapsed
    '{77,    13000,  64,   30,  25,   10},  // R3 truncation
    '{49,    100000, 100,  50,  1,    0},   // R4 exactly vtotal-1
    '{5000,  1000000,2000, 3000,100,  2600} // R3 product above 2^32
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int ht, input int vt, input int vbs, input int pk);
    htotal = 16'(ht); vtotal = 16'(vt); vblank_line = 16'(vbs); pclk_khz = 32'(pk);
  endtask

  task automatic setup_frame(input int ticks);
    ts_tick = 1'b1;
    repeat (3) @(negedge clk);
    ts_tick = 1'b0;
    vblank_stb = 1'b1;
    @(negedge clk);
    vblank_stb = 1'b0;
    ts_tick = 1'b1;
    repeat (ticks) @(negedge clk);
    ts_tick = 1'b0;
  endtask

  task automatic wait_result(output int got);
    got = -1;
    for (int i = 0; i < 400; i++) begin
      if (valid) begin
        got = int'(scanline);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic request(output int got);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    wait_result(got);
  endtask

  initial begin
    int got;
    int nvalid;
    int last;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 scanline after reset", int'(scanline), 0);
    check("R1 valid after reset", int'(valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 R3 R4 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      set_mode(VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][1]);
      setup_frame(VEC[v][0]);
      request(got);
      check($sformatf("R2/R3/R4/R5 vector %0d", v), got, VEC[v][5]);
      @(negedge clk);
    end

    // R6: strobe lands between the two frame-time reads
    set_mode(100, 50, 20, 10000);
    setup_frame(40);
    req = 1'b1; ts_tick = 1'b1;
    @(negedge clk);
    req = 1'b0; ts_tick = 1'b0; vblank_stb = 1'b1;
    @(negedge clk);
    vblank_stb = 1'b0;
    wait_result(got);
    check("R6 retried result uses new frame", got, 20);
    @(negedge clk);

    // R8: requests during busy are dropped; R7 held result
    setup_frame(30);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    nvalid = 0; last = -1;
    for (int i = 0; i < 300; i++) begin
      if (valid) begin nvalid++; last = int'(scanline); end
      req     = (i >= 3 && i < 10);
      ts_tick = (i >= 3 && i < 53);
      @(negedge clk);
    end
    req = 1'b0; ts_tick = 1'b0;
    check("R8 one valid per accepted request", nvalid, 1);
    check("R8 result of first request", last, 23);
    check("R7 scanline held after pulse", int'(scanline), 23);
    check("R7 valid low between results", int'(valid), 0);
    request(got);
    check("R8 next request after done", got, 28);

    ended = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !ended) begin
      ended = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule